// File: doc/BRIEF.md
# Pipelined Four-Term Sum of Products

This block forms the signed value a·b + c·d + e·f + g·h from eight two's-complement operands. It takes one operand set through a valid/ready handshake and returns the exact result with a one-cycle valid pulse. Every operand is registered on entry, so no arithmetic input comes straight from the pins.

A build-time parameter, `NMUL`, sets how many multipliers are built. With four multipliers the datapath is a full pipeline. The four products are registered, then the two pair sums (a·b + c·d and e·f + g·h), then the final sum. In this mode the block accepts a new set on every cycle. With one or two multipliers, a step counter drives operand-select multiplexers, and the products of each step are added into an accumulator. This takes `4/NMUL` steps for one set, so the block drops `in_ready` while it works.

The result is 2·W + 2 bits wide. Each product needs 2·W bits, and the two guard bits absorb the carries of the three additions, so no operand values can make the result overflow.

Top module: `sop_pipe`

## Requirements
- R1: With `NMUL` = 4, every accepted set yields `sum_out` = a·b + c·d + e·f + g·h, exact in two's complement over 2·W + 2 bits. Operands a..h are signed W-bit values.
- R2: With `NMUL` of 1 or 2, every accepted set yields the same exact sum. Operands and `in_valid` are sampled only at an edge where `in_valid` and `in_ready` are both high. Values presented while `in_ready` is low do not change any result.
- R3: The extreme sets give exact results. All operands at the most negative value give +2^(2W). Pairs of most negative and most positive values give the minimum sum. `sum_out` never leaves the range ±2^(2W).
- R4: With `NMUL` = 4, `in_ready` stays high and a set is accepted on every cycle. `out_valid` rises on the fourth rising edge, counting the edge that sampled the set as the first. Results leave in the order the sets were accepted.
- R5: `out_valid` pulses exactly once per accepted set. Cycles with `in_valid` low produce no result.
- R6: With `NMUL` of 1 or 2, a set takes S = 4/`NMUL` accumulate steps. `in_ready` is low from the cycle after acceptance until the cycle of the last step, when it is high again. So sets offered back to back are accepted exactly S cycles apart.
- R7: With `NMUL` of 1 or 2, `out_valid` is a one-cycle pulse. It rises on edge S + 1, counting the sampling edge as the first, which is the edge of the last accumulate.
- R8: While `out_valid` is low, `sum_out` keeps the last result that was delivered.
- R9: `rst` is synchronous and active high. After an edge with `rst` high, `out_valid` is 0, `sum_out` is 0 and `in_ready` is 1. Any set still in flight is discarded and never delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Block can take a set at this edge |
| op_a | input | W | Operand a (signed) |
| op_b | input | W | Operand b (signed) |
| op_c | input | W | Operand c (signed) |
| op_d | input | W | Operand d (signed) |
| op_e | input | W | Operand e (signed) |
| op_f | input | W | Operand f (signed) |
| op_g | input | W | Operand g (signed) |
| op_h | input | W | Operand h (signed) |
| out_valid | output | 1 | One-cycle pulse: sum_out holds a new result |
| sum_out | output | 2W+2 | Signed sum of the four products |

## Verification
The bench runs three configurations with 3-bit operands and sweeps all 64 values of the first operand pair, plus a spread over the other pairs. It also drives the extreme sets. If the guard bits were short, the all-most-negative set would wrap to a negative number. Idle cycles are mixed into the stream, so a pipeline that let an invalid stage through would deliver an extra or duplicated result.

In the shared builds the bench drives changing garbage operands while `in_ready` is low, then offers the next set in the very cycle `in_ready` returns. A design that sampled during the busy period would return the wrong sum. A design that freed the slot one cycle late would break the S-cycle spacing. A design that overwrote the operands too early would corrupt the final step. A reset is also placed between acceptance and delivery: a design that kept a stale valid bit would produce a result.

// File: rtl/sop_pkg.sv
package sop_pkg;
   // Four operand pairs feed the sum; eight operands in all.
   localparam int SOP_PAIRS = 4;
   localparam int SOP_OPS   = 2 * SOP_PAIRS;

   // Accumulate steps per operand set for a given multiplier count.
   function automatic int sop_steps(input int nmul);
      return SOP_PAIRS / nmul;
   endfunction

   // Multiplier counts that divide the pair count evenly.
   function automatic bit sop_nmul_ok(input int nmul);
      return (nmul == 1) || (nmul == 2) || (nmul == 4);
   endfunction
endpackage

// File: rtl/sop_in_reg.sv
module sop_in_reg
   import sop_pkg::*;
#(
   parameter int W = 8
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 load,
   input  logic [SOP_OPS*W-1:0] ops_d,
   output logic [SOP_OPS*W-1:0] ops_q,
   output logic                 vld_q
);
   // Operand capture: pins never reach the multipliers directly.
   always_ff @(posedge clk) begin
      if (rst) begin
         ops_q <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= load;
         if (load) ops_q <= ops_d;
      end
   end
endmodule

// File: rtl/sop_mult.sv
module sop_mult #(
   parameter int W = 8
) (
   input  logic signed [W-1:0]   x,
   input  logic signed [W-1:0]   y,
   output logic signed [2*W-1:0] p
);
   assign p = x * y;
endmodule

// File: rtl/sop_par_core.sv
module sop_par_core
   import sop_pkg::*;
#(
   parameter int W = 8
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     vld_in,
   input  logic [SOP_OPS*W-1:0]     ops,
   output logic                     vld_out,
   output logic signed [2*W+1:0]    sum
);
   localparam int PW = 2 * W;   // product width
   localparam int QW = PW + 1;  // pair-sum width
   localparam int RW = PW + 2;  // final width

   logic signed [PW-1:0] prod_c [SOP_PAIRS];
   logic signed [PW-1:0] prod_q [SOP_PAIRS];
   logic signed [QW-1:0] pair_q [SOP_PAIRS/2];
   logic signed [RW-1:0] sum_q;
   logic                 v1_q, v2_q, v3_q;

   for (genvar i = 0; i < SOP_PAIRS; i++) begin : g_mul
      sop_mult #(.W(W)) u_mul (
         .x ($signed(ops[(2*i)*W +: W])),
         .y ($signed(ops[(2*i+1)*W +: W])),
         .p (prod_c[i])
      );
   end

   // Stage 1: products, stage 2: pair sums, stage 3: final sum.
   // Each stage loads only with valid data so the output holds between results.
   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < SOP_PAIRS; i++) prod_q[i] <= '0;
         for (int j = 0; j < SOP_PAIRS/2; j++) pair_q[j] <= '0;
         sum_q <= '0;
         v1_q  <= 1'b0;
         v2_q  <= 1'b0;
         v3_q  <= 1'b0;
      end else begin
         v1_q <= vld_in;
         v2_q <= v1_q;
         v3_q <= v2_q;
         if (vld_in)
            for (int i = 0; i < SOP_PAIRS; i++) prod_q[i] <= prod_c[i];
         if (v1_q)
            for (int j = 0; j < SOP_PAIRS/2; j++)
               pair_q[j] <= QW'(prod_q[2*j]) + QW'(prod_q[2*j+1]);
         if (v2_q)
            sum_q <= RW'(pair_q[0]) + RW'(pair_q[1]);
      end
   end

   assign vld_out = v3_q;
   assign sum     = sum_q;
endmodule

// File: rtl/sop_shr_core.sv
module sop_shr_core
   import sop_pkg::*;
#(
   parameter int W    = 8,
   parameter int NMUL = 1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     vld_in,
   input  logic [SOP_OPS*W-1:0]     ops,
   output logic                     ready,
   output logic                     vld_out,
   output logic signed [2*W+1:0]    sum
);
   localparam int PW = 2 * W;
   localparam int RW = PW + 2;
   localparam int S  = sop_steps(NMUL);
   localparam int SW = (S > 1) ? $clog2(S) : 1;

   logic [SW-1:0]        step_q, cur;
   logic                 run_q, active, last;
   logic signed [W-1:0]  mx_x [NMUL];
   logic signed [W-1:0]  mx_y [NMUL];
   logic signed [PW-1:0] prod_c [NMUL];
   logic signed [RW-1:0] part, acc_q, acc_base, res_q;
   logic                 ov_q;

   // A fresh set always starts at step 0; otherwise continue the count.
   assign cur      = vld_in ? '0 : step_q;
   assign active   = vld_in | run_q;
   assign last     = (cur == SW'(S - 1));
   assign acc_base = (cur == '0) ? '0 : acc_q;

   // Select multiplexers: step k routes pairs k*NMUL .. k*NMUL+NMUL-1.
   always_comb begin
      for (int j = 0; j < NMUL; j++) begin
         mx_x[j] = $signed(ops[(2*(int'(cur)*NMUL + j))*W +: W]);
         mx_y[j] = $signed(ops[(2*(int'(cur)*NMUL + j) + 1)*W +: W]);
      end
   end

   for (genvar j = 0; j < NMUL; j++) begin : g_mul
      sop_mult #(.W(W)) u_mul (.x(mx_x[j]), .y(mx_y[j]), .p(prod_c[j]));
   end

   always_comb begin
      part = '0;
      for (int j = 0; j < NMUL; j++) part = part + RW'(prod_c[j]);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         step_q <= '0;
         run_q  <= 1'b0;
         acc_q  <= '0;
         res_q  <= '0;
         ov_q   <= 1'b0;
      end else begin
         ov_q <= 1'b0;
         if (active) begin
            if (last) begin
               res_q  <= acc_base + part;
               ov_q   <= 1'b1;
               run_q  <= 1'b0;
               step_q <= '0;
            end else begin
               acc_q  <= acc_base + part;
               step_q <= cur + SW'(1);
               run_q  <= 1'b1;
            end
         end
      end
   end

   // The slot frees during the last step so the next set loads back to back.
   assign ready   = ~active | last;
   assign vld_out = ov_q;
   assign sum     = res_q;

   // R6: a new set never lands while an earlier one is still stepping.
   a_r6_no_overlap: assert property (@(posedge clk) disable iff (rst)
      vld_in |-> !run_q);
endmodule

// File: rtl/sop_pipe.sv
module sop_pipe
   import sop_pkg::*;
#(
   parameter int W    = 8,
   parameter int NMUL = 4
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic signed [W-1:0]     op_a,
   input  logic signed [W-1:0]     op_b,
   input  logic signed [W-1:0]     op_c,
   input  logic signed [W-1:0]     op_d,
   input  logic signed [W-1:0]     op_e,
   input  logic signed [W-1:0]     op_f,
   input  logic signed [W-1:0]     op_g,
   input  logic signed [W-1:0]     op_h,
   output logic                    out_valid,
   output logic signed [2*W+1:0]   sum_out
);
   localparam int RW = 2 * W + 2;
   localparam logic signed [RW-1:0] SUM_LIM = RW'(64'sd1 <<< (2 * W));

   if (!sop_nmul_ok(NMUL) || W < 2) begin : g_bad_cfg
      $error("sop_pipe: NMUL must be 1, 2 or 4 and W at least 2");
   end

   logic [SOP_OPS*W-1:0] ops_d, ops_q;
   logic                 v_q, load;

   assign ops_d = {op_h, op_g, op_f, op_e, op_d, op_c, op_b, op_a};
   assign load  = in_valid & in_ready;

   sop_in_reg #(.W(W)) u_in (
      .clk (clk), .rst (rst), .load (load),
      .ops_d (ops_d), .ops_q (ops_q), .vld_q (v_q)
   );

   if (NMUL == SOP_PAIRS) begin : g_par
      assign in_ready = 1'b1;
      sop_par_core #(.W(W)) u_core (
         .clk (clk), .rst (rst), .vld_in (v_q), .ops (ops_q),
         .vld_out (out_valid), .sum (sum_out)
      );
      // R4: fixed latency of four edges from sampling to result.
      a_r4_par_latency: assert property (@(posedge clk) disable iff (rst)
         in_valid |-> ##4 out_valid);
   end else begin : g_shr
      sop_shr_core #(.W(W), .NMUL(NMUL)) u_core (
         .clk (clk), .rst (rst), .vld_in (v_q), .ops (ops_q),
         .ready (in_ready), .vld_out (out_valid), .sum (sum_out)
      );
      // R6: acceptance makes the block busy on the next cycle.
      a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
         (in_valid && in_ready) |=> !in_ready);
      // R7: results leave as single-cycle pulses.
      a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
         out_valid |=> !out_valid);
   end

   // R3: the guard bits keep every delivered sum inside +/-2^(2W).
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (sum_out <= SUM_LIM && sum_out >= -SUM_LIM));

   // R9: a reset edge leaves the block idle and cleared.
   a_r9_reset_state: assert property (@(posedge clk)
      rst |=> (!out_valid && sum_out == '0 && in_ready));
endmodule

// File: tb/tb_sop_pipe.sv
module sop_lane #(
   parameter int W    = 3,
   parameter int NMUL = 4,
   parameter int NV   = 140
) (
   input  logic clk,
   output int   n_chk,
   output int   n_bad,
   output logic done
);
   localparam int S   = 4 / NMUL;
   localparam int LAT = (NMUL == 4) ? 4 : S + 1;
   localparam int GAP = (NMUL == 4) ? 1 : S;
   localparam int RW  = 2 * W + 2;

   logic                 rst = 1'b1;
   logic                 iv  = 1'b0;
   logic signed [W-1:0]  o [8];
   logic                 rdy, ov;
   logic signed [RW-1:0] sum;

   sop_pipe #(.W(W), .NMUL(NMUL)) dut (
      .clk (clk), .rst (rst), .in_valid (iv), .in_ready (rdy),
      .op_a (o[0]), .op_b (o[1]), .op_c (o[2]), .op_d (o[3]),
      .op_e (o[4]), .op_f (o[5]), .op_g (o[6]), .op_h (o[7]),
      .out_valid (ov), .sum_out (sum)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int exp_v [NV];
   int iss   [NV];
   int wr = 0;
   int rd = 0;
   int d_chk = 0, d_bad = 0, m_chk = 0, m_bad = 0;
   bit mon_en = 1'b0;
   bit have_last = 1'b0;
   bit prev_ov = 1'b0;
   int last = 0;

   assign n_chk = d_chk + m_chk;
   assign n_bad = d_bad + m_bad;

   // Operand k (0=a .. 7=h) of set t.
   function automatic int pat(input int t, input int k);
      int lo, hi, span;
      lo   = -(1 << (W - 1));
      hi   = (1 << (W - 1)) - 1;
      span = 1 << W;
      if (t == 0) return lo;
      if (t == 1) return (k % 2 == 0) ? lo : hi;
      if (t == 2) return hi;
      if (t == 3) return 0;
      if (t >= 8 && t < 8 + span * span && k < 2)
         return (k == 0) ? ((t - 8) / span) + lo : ((t - 8) % span) + lo;
      return ((t * 5 + k * 3 + t * k * 7 + t / 8) % span) + lo;
   endfunction

   function automatic int ref_of(input int t);
      int s;
      s = 0;
      for (int i = 0; i < 4; i++) s += pat(t, 2 * i) * pat(t, 2 * i + 1);
      return s;
   endfunction

   function automatic string tagv(input int t);
      if (t < 3) return "R3";
      return (NMUL == 4) ? "R1" : "R2";
   endfunction

   task automatic drive(input int t);
      for (int k = 0; k < 8; k++) o[k] = W'(pat(t, k));
   endtask

   task automatic dcheck(input bit ok, input string req, input int act, input int expv);
      d_chk++;
      if (!ok) begin
         d_bad++;
         $display("FAIL %s (NMUL=%0d): actual %0d expected %0d", req, NMUL, act, expv);
      end
   endtask

   task automatic mcheck(input bit ok, input string req, input int act, input int expv);
      m_chk++;
      if (!ok) begin
         m_bad++;
         $display("FAIL %s (NMUL=%0d): actual %0d expected %0d", req, NMUL, act, expv);
      end
   endtask

   // Output monitor: value, latency, pulse shape and hold behaviour.
   always @(negedge clk) begin
      if (mon_en) begin
         if (ov) begin
            if (rd >= wr) mcheck(1'b0, "R5", rd, wr);
            else begin
               mcheck(int'(sum) == exp_v[rd], tagv(rd), int'(sum), exp_v[rd]);
               mcheck(cyc - iss[rd] == LAT, (NMUL == 4) ? "R4" : "R7", cyc - iss[rd], LAT);
               last      = exp_v[rd];
               have_last = 1'b1;
               rd++;
            end
            if (NMUL != 4) mcheck(!prev_ov, "R7", int'(prev_ov), 0);
         end else if (have_last) begin
            mcheck(int'(sum) == last, "R8", int'(sum), last);
         end
      end
      prev_ov = ov;
   end

   initial begin
      bit bub;
      done = 1'b0;
      for (int k = 0; k < 8; k++) o[k] = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R9: state after power-up reset.
      dcheck(!ov, "R9", int'(ov), 0);
      dcheck(sum == '0, "R9", int'(sum), 0);
      dcheck(rdy, "R9", int'(rdy), 1);
      mon_en = 1'b1;

      for (int t = 0; t < NV; t++) begin
         bub = (t % 5 == 3);
         if (bub) begin
            iv = 1'b0;
            drive(t + 300);
            @(negedge clk);
         end
         // R2: garbage offered while busy must be ignored.
         while (!rdy) begin
            iv = 1'b1;
            drive(t + 300);
            @(negedge clk);
         end
         iv = 1'b1;
         drive(t);
         exp_v[t] = ref_of(t);
         iss[t]   = cyc;
         wr       = t + 1;
         if (t > 0 && !bub)
            dcheck(iss[t] - iss[t-1] == GAP, (NMUL == 4) ? "R4" : "R6",
                   iss[t] - iss[t-1], GAP);
         @(negedge clk);
         if (NMUL != 4) dcheck(!rdy, "R6", int'(rdy), 0);
      end
      iv = 1'b0;
      drive(999);
      for (int k = 0; k < 40 && rd < NV; k++) @(negedge clk);
      repeat (6) @(negedge clk);
      dcheck(rd == NV, "R5", rd, NV);
      mon_en = 1'b0;

      // R9: a reset while a set is in flight discards it.
      iv = 1'b1;
      drive(7);
      @(negedge clk);
      iv = 1'b0;
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      for (int k = 0; k < 8; k++) begin
         dcheck(!ov, "R9", int'(ov), 0);
         dcheck(sum == '0, "R9", int'(sum), 0);
         dcheck(rdy, "R9", int'(rdy), 1);
         @(negedge clk);
      end
      done = 1'b1;
   end
endmodule

module tb_sop_pipe;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   int   c4, b4, c1, b1, c2, b2;
   logic d4, d1, d2;

   sop_lane #(.W(3), .NMUL(4)) lane_par (.clk(clk), .n_chk(c4), .n_bad(b4), .done(d4));
   sop_lane #(.W(3), .NMUL(1)) lane_one (.clk(clk), .n_chk(c1), .n_bad(b1), .done(d1));
   sop_lane #(.W(3), .NMUL(2)) lane_two (.clk(clk), .n_chk(c2), .n_bad(b2), .done(d2));

   initial begin
      int tot, bad;
      bit expired;
      expired = 1'b0;
      @(posedge clk);
      for (int k = 0; k < 20000 && !(d4 && d1 && d2); k++) @(posedge clk);
      if (!(d4 && d1 && d2)) begin
         expired = 1'b1;
         $display("FAIL R5 watchdog expired: actual 0 expected 1");
      end
      @(negedge clk);
      tot = c4 + c1 + c2 + (expired ? 1 : 0);
      bad = b4 + b1 + b2 + (expired ? 1 : 0);
      $display("[TB] %0d tests run, %0d failed", tot, bad);
      $finish;
   end
endmodule